// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the master side of the two-wire station management bus used to reach Ethernet PHY registers. It generates the management clock (MDC) and drives the bidirectional data line through separate output, output-enable and input pins. An external pad combines these into the shared line, and a pull-up holds the line high when nobody drives it. A single command starts one complete management transaction, and the block then sequences every bit without further help.

Four operations are supported. Clause 22 read and write are each a single frame. Clause 45 read and write are each an address frame, which loads the 16-bit register address, followed immediately by the data frame for the same PHY and device. The block checks the turnaround bit on reads. When a PHY fails to pull it low, the block flushes the bus with extra clocks and reports an error, unless that PHY is marked in a 32-bit mask as having a broken turnaround. MDC phase lengths are parameters counted in system clocks. The Clause 22 opcodes can be replaced through configuration inputs.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions, `busy` is 0, MDC is low and `mdio_oe` is 0. `busy` rises in the cycle after a command is accepted and falls in the same cycle that `done` is high. `done` is high for exactly one cycle.
- R2: Every MDC low phase lasts HALF_CYC system clocks. The high phase lasts HALF_CYC clocks for a bit driven by the master and READ_CYC clocks for a bit with MDIO released. The line is sampled at the end of the high phase.
- R3: Every frame begins with 32 driven one bits. Next come 2 start bits and 2 opcode bits, then the 5-bit PHY address and a 5-bit field. Every multi-bit field is sent MSB first. The field is the register number in Clause 22 and the device address in Clause 45.
- R4: Clause 22 frames use start bits 0,1. With `cfg_op_sel`=0 the opcode is 1,0 for a read (`cmd_op`=0) and 0,1 for a write (`cmd_op`=1). With `cfg_op_sel`=1 the opcodes come from `cfg_rd_opc` and `cfg_wr_opc`, with bit 1 sent first.
- R5: A write or address frame drives turnaround 1,0 and then 16 payload bits, MSB first. It then releases MDIO for one extra clock, giving 65 MDC clocks per frame.
- R6: A Clause 45 command (`cmd_op`=2 read, 3 write) first sends an address frame with start 0,0, opcode 0,0 and payload `cmd_addr`. With no gap, a frame with start 0,0 follows, with opcode 1,1 for a read or 0,1 for a write, carrying the same PHY and device address.
- R7: A read frame releases MDIO after the 14 header bits and clocks one turnaround bit. If that bit reads 0, the frame shifts in 16 data bits MSB first into `rdata`, clocks one idle bit and clears `err`. The frame is 64 MDC clocks in total.
- R8: If the turnaround bit reads 1 and bit `cmd_phy` of `ta_ignore_mask` is 0, the block clocks 32 more released bits, for 79 clocks in the frame. At `done` it sets `rdata` to 16'hFFFF and `err` to 1.
- R9: If the turnaround bit reads 1 and the PHY's mask bit is set, the read proceeds as in R7.
- R10: A `cmd_valid` pulse while `busy` is 1 is ignored. It does not change the bits of the frame in progress and does not start a transaction afterwards.
- R11: While MDC is high, a driven MDIO value does not change. `mdio_oe` changes only when MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when `busy` is 0 |
| cmd_op | input | 2 | 0 C22 read, 1 C22 write, 2 C45 read, 3 C45 write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number (C22) or device address (C45) |
| cmd_addr | input | 16 | Register address for the C45 address frame |
| cmd_wdata | input | 16 | Write data |
| cfg_op_sel | input | 1 | 1 selects the configured Clause 22 opcodes |
| cfg_rd_opc | input | 2 | Replacement Clause 22 read opcode |
| cfg_wr_opc | input | 2 | Replacement Clause 22 write opcode |
| ta_ignore_mask | input | 32 | Per-PHY flag to ignore a bad turnaround |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last read saw a bad turnaround |
| rdata | output | 16 | Last read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The hardest case to reach is the failed turnaround. It needs a responder that leaves the line high in exactly the one released bit after the header, and the mask has to decide the outcome for that one PHY address. The bench contains a behavioural PHY that follows every MDC rise. Its expected-bit queue tells it, for each released bit, what level to present, so the turnaround can be driven high with the mask bit both clear and set. The same queue covers the chained Clause 45 frames, so the seam between the address frame and the data frame is checked bit by bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        OP_C22_RD = 2'd0,
        OP_C22_WR = 2'd1,
        OP_C45_RD = 2'd2,
        OP_C45_WR = 2'd3
    } mdio_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_TAIL,
        SQ_TA,
        SQ_DATA,
        SQ_END,
        SQ_FLUSH
    } seq_state_e;

    typedef enum logic [1:0] {
        BT_IDLE,
        BT_LOW,
        BT_HIGH
    } bit_state_e;

    localparam int PREAMBLE_BITS = 32;
    localparam int HDR_BITS      = 14;
    localparam int TA_BITS       = 2;
    localparam int FIELD_BITS    = 16;
    localparam int FLUSH_BITS    = 32;
    localparam int FRAME_BITS    = PREAMBLE_BITS + HDR_BITS + TA_BITS + FIELD_BITS;
    localparam int READ_TX_BITS  = PREAMBLE_BITS + HDR_BITS;

    typedef struct packed {
        logic [1:0]            start;
        logic [1:0]            opc;
        logic [4:0]            phy;
        logic [4:0]            fld;
        logic [FIELD_BITS-1:0] payload;
    } frame_t;

    function automatic logic [FRAME_BITS-1:0] pack_frame(input frame_t f);
        return {{PREAMBLE_BITS{1'b1}}, f.start, f.opc, f.phy, f.fld, 2'b10, f.payload};
    endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 25,
    parameter int READ_CYC = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rx_bit,
    input  logic last_bit,
    input  logic mdio_i,
    output logic mdc,
    output logic bit_done,
    output logic bit_sample
);
    localparam int MAXC = (READ_CYC > HALF_CYC) ? READ_CYC : HALF_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HALF_LOAD = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] READ_LOAD = CW'(READ_CYC - 1);

    bit_state_e    st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BT_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                BT_IDLE: begin
                    if (start) begin
                        st  <= BT_LOW;
                        cnt <= HALF_LOAD;
                    end
                end
                BT_LOW: begin
                    if (cnt == '0) begin
                        st  <= BT_HIGH;
                        cnt <= rx_bit ? READ_LOAD : HALF_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BT_HIGH: begin
                    if (cnt == '0) begin
                        st  <= last_bit ? BT_IDLE : BT_LOW;
                        cnt <= HALF_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= BT_IDLE;
            endcase
        end
    end

    assign mdc        = (st == BT_HIGH);
    assign bit_done   = (st == BT_HIGH) && (cnt == '0);
    assign bit_sample = mdio_i;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_addr,
    input  logic [15:0] cmd_wdata,
    input  logic        cfg_op_sel,
    input  logic [1:0]  cfg_rd_opc,
    input  logic [1:0]  cfg_wr_opc,
    input  logic [31:0] ta_ignore_mask,
    input  logic        bit_done,
    input  logic        bit_sample,
    output logic        accept,
    output logic        busy,
    output logic        rx_bit,
    output logic        last_bit,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LOAD_TX    = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LOAD_RDHDR = CNT_W'(READ_TX_BITS - 1);
    localparam logic [CNT_W-1:0] LOAD_DATA  = CNT_W'(FIELD_BITS - 1);
    localparam logic [CNT_W-1:0] LOAD_FLUSH = CNT_W'(FLUSH_BITS - 1);

    seq_state_e            state;
    logic [FRAME_BITS-1:0] sreg;
    logic [CNT_W-1:0]      cnt;
    logic                  pend;
    frame_t                f2_q;
    logic                  f2_rx_q;
    logic                  cur_rx;
    logic [4:0]            phy_q;
    logic [15:0]           rx_sh;

    frame_t   f_first;
    frame_t   f_second;
    logic     first_rx;
    logic     second_rx;
    logic     two_frames;
    logic [1:0] c22_rd;
    logic [1:0] c22_wr;

    always_comb begin
        c22_rd     = cfg_op_sel ? cfg_rd_opc : 2'b10;
        c22_wr     = cfg_op_sel ? cfg_wr_opc : 2'b01;
        two_frames = 1'b0;
        first_rx   = 1'b0;
        second_rx  = (mdio_op_e'(cmd_op) == OP_C45_RD);
        f_second   = '{start: 2'b00, opc: second_rx ? 2'b11 : 2'b01,
                       phy: cmd_phy, fld: cmd_reg, payload: cmd_wdata};
        case (mdio_op_e'(cmd_op))
            OP_C22_RD: begin
                f_first  = '{start: 2'b01, opc: c22_rd, phy: cmd_phy, fld: cmd_reg, payload: cmd_wdata};
                first_rx = 1'b1;
            end
            OP_C22_WR: begin
                f_first  = '{start: 2'b01, opc: c22_wr, phy: cmd_phy, fld: cmd_reg, payload: cmd_wdata};
            end
            default: begin
                f_first    = '{start: 2'b00, opc: 2'b00, phy: cmd_phy, fld: cmd_reg, payload: cmd_addr};
                two_frames = 1'b1;
            end
        endcase
    end

    assign accept   = cmd_valid && (state == SQ_IDLE);
    assign busy     = (state != SQ_IDLE);
    assign rx_bit   = (state != SQ_IDLE) && (state != SQ_SEND);
    assign last_bit = ((state == SQ_TAIL) && !pend) || (state == SQ_END) ||
                      ((state == SQ_FLUSH) && (cnt == '0));
    assign mdio_oe  = (state == SQ_SEND);
    assign mdio_o   = (state == SQ_SEND) && sreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            sreg    <= '0;
            cnt     <= '0;
            pend    <= 1'b0;
            f2_q    <= '0;
            f2_rx_q <= 1'b0;
            cur_rx  <= 1'b0;
            phy_q   <= '0;
            rx_sh   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state   <= SQ_SEND;
                sreg    <= pack_frame(f_first);
                cnt     <= first_rx ? LOAD_RDHDR : LOAD_TX;
                cur_rx  <= first_rx;
                pend    <= two_frames;
                f2_q    <= f_second;
                f2_rx_q <= second_rx;
                phy_q   <= cmd_phy;
                err     <= 1'b0;
            end else if (bit_done) begin
                case (state)
                    SQ_SEND: begin
                        if (cnt == '0) begin
                            state <= cur_rx ? SQ_TA : SQ_TAIL;
                        end else begin
                            sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
                            cnt  <= cnt - 1'b1;
                        end
                    end
                    SQ_TAIL: begin
                        if (pend) begin
                            state  <= SQ_SEND;
                            sreg   <= pack_frame(f2_q);
                            cnt    <= f2_rx_q ? LOAD_RDHDR : LOAD_TX;
                            cur_rx <= f2_rx_q;
                            pend   <= 1'b0;
                        end else begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    SQ_TA: begin
                        if (bit_sample && !ta_ignore_mask[phy_q]) begin
                            state <= SQ_FLUSH;
                            cnt   <= LOAD_FLUSH;
                        end else begin
                            state <= SQ_DATA;
                            cnt   <= LOAD_DATA;
                        end
                    end
                    SQ_DATA: begin
                        rx_sh <= {rx_sh[14:0], bit_sample};
                        if (cnt == '0) begin
                            state <= SQ_END;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SQ_END: begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                        rdata <= rx_sh;
                        err   <= 1'b0;
                    end
                    SQ_FLUSH: begin
                        if (cnt == '0) begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                            rdata <= 16'hFFFF;
                            err   <= 1'b1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 25,
    parameter int READ_CYC = 35
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_addr,
    input  logic [15:0] cmd_wdata,
    input  logic        cfg_op_sel,
    input  logic [1:0]  cfg_rd_opc,
    input  logic [1:0]  cfg_wr_opc,
    input  logic [31:0] ta_ignore_mask,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic accept;
    logic rx_bit;
    logic last_bit;
    logic bit_done;
    logic bit_sample;

    mdio_frame_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_phy        (cmd_phy),
        .cmd_reg        (cmd_reg),
        .cmd_addr       (cmd_addr),
        .cmd_wdata      (cmd_wdata),
        .cfg_op_sel     (cfg_op_sel),
        .cfg_rd_opc     (cfg_rd_opc),
        .cfg_wr_opc     (cfg_wr_opc),
        .ta_ignore_mask (ta_ignore_mask),
        .bit_done       (bit_done),
        .bit_sample     (bit_sample),
        .accept         (accept),
        .busy           (busy),
        .rx_bit         (rx_bit),
        .last_bit       (last_bit),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe),
        .done           (done),
        .err            (err),
        .rdata          (rdata)
    );

    mdio_bit_timer #(
        .HALF_CYC (HALF_CYC),
        .READ_CYC (READ_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .rx_bit     (rx_bit),
        .last_bit   (last_bit),
        .mdio_i     (mdio_i),
        .mdc        (mdc),
        .bit_done   (bit_done),
        .bit_sample (bit_sample)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r1_busy_falls_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r8_err_value: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (rdata == 16'hFFFF));

    a_r11_data_steady: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

    a_r11_oe_low_clock: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe != $past(mdio_oe)) |-> !mdc);

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rdata   (rdata),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int HALF = 25;
    localparam int READ = 35;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cfg_op_sel = 1'b0;
    logic [1:0]  cfg_rd_opc = 2'b00;
    logic [1:0]  cfg_wr_opc = 2'b00;
    logic [31:0] ta_ignore_mask = 32'h0000_0200;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i;

    always #5 clk = ~clk;

    mdio_master #(.HALF_CYC(HALF), .READ_CYC(READ)) u_mdio_master (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cfg_op_sel(cfg_op_sel), .cfg_rd_opc(cfg_rd_opc),
        .cfg_wr_opc(cfg_wr_opc), .ta_ignore_mask(ta_ignore_mask), .busy(busy),
        .done(done), .err(err), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // expected bit per MDC rise: {released, value}
    logic [1:0] expq[$];
    int  rise_cnt, frame_err, timing_err, lo_run, hi_run;
    bit  prev_mdc, prev_oe, prev_o, cur_rx;
    logic [15:0] model_rdata = 16'h0000;

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            report();
        end
    end

    // behavioural PHY and MDC timing monitor
    always @(negedge clk) begin
        if (rst) begin
            prev_mdc = 1'b0; prev_oe = 1'b0; prev_o = 1'b0;
            lo_run = 0; hi_run = 0; mdio_i = 1'b1; cur_rx = 1'b0;
        end else begin
            if (mdc && !prev_mdc) begin
                rise_cnt++;
                if (lo_run != HALF) timing_err++;
                lo_run = 0; hi_run = 1; cur_rx = !mdio_oe;
                if (expq.size() == 0) frame_err++;
                else begin
                    logic [1:0] e;
                    e = expq.pop_front();
                    if (e[1]) begin
                        if (mdio_oe) frame_err++;
                        mdio_i = e[0];
                    end else if (!mdio_oe || mdio_o !== e[0]) frame_err++;
                end
            end else if (!mdc && prev_mdc) begin
                if (hi_run != (cur_rx ? READ : HALF)) timing_err++;
                hi_run = 0;
                lo_run = busy ? 1 : 0;
            end else if (mdc) begin
                hi_run++;
                if (prev_mdc && (mdio_oe != prev_oe || (mdio_oe && mdio_o != prev_o)))
                    timing_err++;
            end else if (busy) begin
                lo_run++;
            end
            prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
        end
    end

    task automatic push_tx(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) expq.push_back({1'b0, v[i]});
    endtask

    task automatic push_rx(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) expq.push_back({1'b1, v[i]});
    endtask

    task automatic push_hdr(input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] fld);
        push_tx(32'hFFFF_FFFF, 32);
        push_tx({28'd0, st, op}, 4);
        push_tx({27'd0, phy}, 5);
        push_tx({27'd0, fld}, 5);
    endtask

    task automatic push_write_body(input logic [15:0] v);
        push_tx(32'd2, 2);
        push_tx({16'd0, v}, 16);
        push_rx(32'd1, 1);
    endtask

    task automatic push_read_body(input logic [4:0] phy, input bit bad_ta,
                                  input logic [15:0] rsp, output bit exp_err);
        push_rx({31'd0, bad_ta}, 1);
        if (bad_ta && !ta_ignore_mask[phy]) begin
            push_rx(32'hFFFF_FFFF, 32);
            exp_err = 1'b1;
            model_rdata = 16'hFFFF;
        end else begin
            push_rx({16'd0, rsp}, 16);
            push_rx(32'd1, 1);
            exp_err = 1'b0;
            model_rdata = rsp;
        end
    endtask

    task automatic run_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] fld,
                           input logic [15:0] addr, input logic [15:0] wd, input bit bad_ta,
                           input logic [15:0] rsp, input bit poke, input string tag);
        bit exp_err = 1'b0;
        int nbits, wait_cnt;
        logic [1:0] rd_opc, wr_opc;
        expq.delete();
        rd_opc = cfg_op_sel ? cfg_rd_opc : 2'b10;
        wr_opc = cfg_op_sel ? cfg_wr_opc : 2'b01;
        case (op)
            2'd0: begin push_hdr(2'b01, rd_opc, phy, fld); push_read_body(phy, bad_ta, rsp, exp_err); end
            2'd1: begin push_hdr(2'b01, wr_opc, phy, fld); push_write_body(wd); end
            2'd2: begin
                push_hdr(2'b00, 2'b00, phy, fld); push_write_body(addr);
                push_hdr(2'b00, 2'b11, phy, fld); push_read_body(phy, bad_ta, rsp, exp_err);
            end
            default: begin
                push_hdr(2'b00, 2'b00, phy, fld); push_write_body(addr);
                push_hdr(2'b00, 2'b01, phy, fld); push_write_body(wd);
            end
        endcase
        nbits = expq.size();
        rise_cnt = 0; frame_err = 0; timing_err = 0;
        @(negedge clk);
        cmd_op = op; cmd_phy = phy; cmd_reg = fld; cmd_addr = addr; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R1", {tag, " busy after accept"}, busy, 1);
        if (poke) begin
            repeat (300) @(negedge clk);
            cmd_op = 2'd1; cmd_phy = ~phy; cmd_reg = ~fld; cmd_wdata = ~wd;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wait_cnt = 0;
        while (!done && wait_cnt < 20000) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(done == 1'b1, "R1", {tag, " done seen"}, done, 1);
        chk(rdata == model_rdata, tag, "rdata", rdata, model_rdata);
        chk(err == exp_err, tag, "err", err, exp_err);
        @(negedge clk);
        chk(!done && !busy, "R1", {tag, " done single cycle"}, {done, busy}, 0);
        @(negedge clk);
        chk(frame_err == 0 && expq.size() == 0, tag, "frame bits", frame_err, 0);
        chk(rise_cnt == nbits, tag, "MDC clocks", rise_cnt, nbits);
        chk(timing_err == 0, "R2/R11", {tag, " phase timing"}, timing_err, 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            chk(!busy && !mdc, "R10", "no command started from busy strobe", busy, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mdc && !mdio_oe && !done, "R1", "reset state",
            {busy, mdc, mdio_oe, done}, 0);
        run_txn(2'd1, 5'd5, 5'h11, 16'h0, 16'hA5C3, 1'b0, 16'h0, 1'b0, "R3/R4/R5 c22 write");
        run_txn(2'd0, 5'd2, 5'h01, 16'h0, 16'h0, 1'b0, 16'h1234, 1'b0, "R3/R4/R7 c22 read");
        run_txn(2'd0, 5'd3, 5'h02, 16'h0, 16'h0, 1'b1, 16'h1234, 1'b0, "R8 c22 bad turnaround");
        run_txn(2'd0, 5'd9, 5'h03, 16'h0, 16'h0, 1'b1, 16'hBEEF, 1'b0, "R9 masked turnaround");
        run_txn(2'd3, 5'd1, 5'h1E, 16'h8001, 16'h00FF, 1'b0, 16'h0, 1'b0, "R6 c45 write");
        run_txn(2'd2, 5'd31, 5'h03, 16'h0020, 16'h0, 1'b0, 16'h5A5A, 1'b0, "R6/R7 c45 read");
        run_txn(2'd2, 5'd4, 5'h07, 16'hC0DE, 16'h0, 1'b1, 16'h0, 1'b0, "R6/R8 c45 bad turnaround");
        cfg_op_sel = 1'b1; cfg_rd_opc = 2'b11; cfg_wr_opc = 2'b00;
        run_txn(2'd0, 5'd6, 5'h0A, 16'h0, 16'h0, 1'b0, 16'h8001, 1'b0, "R4 override read");
        run_txn(2'd1, 5'd6, 5'h0B, 16'h0, 16'h3C3C, 1'b0, 16'h0, 1'b0, "R4 override write");
        cfg_op_sel = 1'b0;
        run_txn(2'd0, 5'd12, 5'h15, 16'h0, 16'h0, 1'b0, 16'h0F0F, 1'b1, "R10 strobe while busy");
        report();
    end

endmodule